// File: doc/BRIEF.md
# Reference Clock Presence Monitor

This block decides whether a slow, asynchronous reference clock (nominally 8 kHz) is actually toggling. It works entirely in a fast local clock domain. The reference pin is first brought into that domain through a flop chain. Its low-to-high transitions are then detected and counted over consecutive fixed observation windows. Each window lasts three reference periods, measured in local-clock cycles.

When a window closes, the edge tally is compared with a threshold of two and a present/lost flag is registered. A select output follows that flag. When high, it tells the downstream synthesizer loop to track the reference. When low, it tells the loop to coast at the oscillator's center frequency. Monitoring never stops, so a reference that disappears and later comes back is declared present again at the first qualifying window.

The ratio between the local clock and the reference defaults to 4416. The window therefore defaults to 13248 cycles. Both the ratio and the number of periods per window are parameters, so simulation can use short windows.

Top module: `refmon_top`

## Requirements
- R1: While `rst_n` is low and after its release until the first window closes, `ref_ok`, `sel_lock`, `win_done` and `last_edges` are all 0 (reference treated as lost).
- R2: `win_done` pulses for exactly one cycle at the close of every window, and consecutive pulses are exactly `REF_RATIO*WIN_PERIODS` clock cycles apart; the first pulse comes that many cycles after reset release.
- R3: `last_edges` reports the number of rising transitions of `ref_in` seen during the window just closed, saturating at `WIN_PERIODS` (3 by default); a level held high without a new low-to-high transition adds nothing.
- R4: A closed window with fewer than `EDGE_THRESH` (2) rising edges sets `ref_ok` to 0.
- R5: A closed window with at least `EDGE_THRESH` rising edges sets `ref_ok` to 1.
- R6: After a lost verdict, the next window that meets the threshold sets `ref_ok` back to 1 with no other action.
- R7: `sel_lock` always equals `ref_ok`: 1 requests locking to the reference, 0 requests free-running at center frequency.
- R8: `ref_ok`, `sel_lock` and `last_edges` change only in the cycle where `win_done` is 1 and hold their value between window closes.
- R9: The edge tally starts from zero in every window, so edges from an earlier window never raise a later window's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Asynchronous slow reference clock |
| ref_ok | output | 1 | 1 = reference judged present by the last closed window |
| sel_lock | output | 1 | 1 = lock to reference, 0 = free-run at center frequency |
| win_done | output | 1 | One-cycle pulse marking the close of a window |
| last_edges | output | $clog2(WIN_PERIODS+1) | Saturated rising-edge count of the last closed window |

## Verification
A corrupted window timer shows up as a `win_done` spacing different from the window length. This is visible at the very next close, so within one window. A tally that fails to clear, or that counts falling edges or held levels, shows up in `last_edges` at the close of the affected window. A wrong threshold flips `ref_ok` and `sel_lock` at that same close. Any spurious update of the verdict between closes is seen in the cycle it happens, because `ref_ok` and `last_edges` are compared with their last latched values on every cycle.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    // Verdict encoding for the presence flag.
    typedef enum logic {
        REF_LOST    = 1'b0,
        REF_PRESENT = 1'b1
    } ref_state_e;

endpackage

// File: rtl/refmon_sync.sv
// Brings the asynchronous reference into the local domain and flags
// every low-to-high transition with a one-cycle pulse.
module refmon_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic ref_rise
);
    // Bit SYNC_STAGES holds the previous synchronized level for edge detection.
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = ref_async;
        for (int i = 1; i < CHAIN_W; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_rise = st_q.chain[SYNC_STAGES-1] & ~st_q.chain[SYNC_STAGES];

endmodule

// File: rtl/refmon_window.sv
// Free-running window timer: raises win_last in the final cycle of each window.
module refmon_window #(
    parameter int WIN_CYCLES = 13248
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_last
);
    localparam int TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.tmr == LAST) begin
            st_d.tmr = '0;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_last = (st_q.tmr == LAST);

endmodule

// File: rtl/refmon_judge.sv
// Saturating edge tally plus the verdict register updated at window close.
module refmon_judge
    import refmon_pkg::*;
#(
    parameter int MAX_EDGES   = 3,
    parameter int EDGE_THRESH = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rise,
    input  logic                               win_last,
    output logic                               present,
    output logic                               done,
    output logic [$clog2(MAX_EDGES+1)-1:0]     edges
);
    localparam int CW = $clog2(MAX_EDGES + 1);
    localparam logic [CW-1:0] CMAX = CW'(MAX_EDGES);
    localparam logic [CW-1:0] CTHR = CW'(EDGE_THRESH);

    typedef struct packed {
        logic [CW-1:0] tally;
        logic [CW-1:0] last;
        ref_state_e    verdict;
        logic          done;
    } judge_state_t;

    judge_state_t st_d, st_q;
    logic [CW-1:0] tally_now;

    always_comb begin
        // An edge in the closing cycle still belongs to the closing window.
        tally_now = st_q.tally;
        if (rise && (st_q.tally != CMAX)) begin
            tally_now = st_q.tally + 1'b1;
        end

        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.tally = tally_now;
        if (win_last) begin
            st_d.last    = tally_now;
            st_d.verdict = (tally_now >= CTHR) ? REF_PRESENT : REF_LOST;
            st_d.done    = 1'b1;
            st_d.tally   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tally: '0, last: '0, verdict: REF_LOST, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign present = (st_q.verdict == REF_PRESENT);
    assign done    = st_q.done;
    assign edges   = st_q.last;

endmodule

// File: rtl/refmon_top.sv
module refmon_top #(
    parameter int REF_RATIO   = 4416,
    parameter int WIN_PERIODS = 3,
    parameter int EDGE_THRESH = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ref_in,
    output logic                               ref_ok,
    output logic                               sel_lock,
    output logic                               win_done,
    output logic [$clog2(WIN_PERIODS+1)-1:0]   last_edges
);
    localparam int WIN_CYCLES = REF_RATIO * WIN_PERIODS;

    logic rise;
    logic win_last;
    logic present;

    refmon_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_async (ref_in),
        .ref_rise  (rise)
    );

    refmon_window #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_last (win_last)
    );

    refmon_judge #(
        .MAX_EDGES   (WIN_PERIODS),
        .EDGE_THRESH (EDGE_THRESH)
    ) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .win_last (win_last),
        .present  (present),
        .done     (win_done),
        .edges    (last_edges)
    );

    assign ref_ok   = present;
    assign sel_lock = present;

endmodule

// File: rtl/refmon_checker.sv
module refmon_checker #(
    parameter int REF_RATIO   = 4416,
    parameter int WIN_PERIODS = 3,
    parameter int EDGE_THRESH = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               ref_ok,
    input logic                               sel_lock,
    input logic                               win_done,
    input logic [$clog2(WIN_PERIODS+1)-1:0]   last_edges
);
    localparam int WIN_CYCLES = REF_RATIO * WIN_PERIODS;

    // Cycles since reset release or since the last close pulse.
    int unsigned since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
        end else if (win_done) begin
            since_q <= 1;
        end else begin
            since_q <= since_q + 1;
        end
    end

    a_r2_period_exact: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (since_q == WIN_CYCLES));

    a_r2_never_late: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= WIN_CYCLES);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    a_r4_lost_below: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && (int'(last_edges) < EDGE_THRESH)) |-> !ref_ok);

    a_r5_present_at: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && (int'(last_edges) >= EDGE_THRESH)) |-> ref_ok);

    a_r7_select_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lock == ref_ok);

    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(ref_ok));

    a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(last_edges));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(last_edges) <= WIN_PERIODS);

endmodule

bind refmon_top refmon_checker #(
    .REF_RATIO   (REF_RATIO),
    .WIN_PERIODS (WIN_PERIODS),
    .EDGE_THRESH (EDGE_THRESH)
) u_refmon_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_ok     (ref_ok),
    .sel_lock   (sel_lock),
    .win_done   (win_done),
    .last_edges (last_edges)
);

// File: tb/refmon_top_bench.sv
module refmon_top_bench;

    localparam int RATIO   = 20;
    localparam int PERIODS = 3;
    localparam int THRESH  = 2;
    localparam int WIN     = RATIO * PERIODS;
    localparam int EW      = $clog2(PERIODS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in = 1'b0;
    logic          ref_ok;
    logic          sel_lock;
    logic          win_done;
    logic [EW-1:0] last_edges;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        int cnt;
        bit ok;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    refmon_top #(
        .REF_RATIO   (RATIO),
        .WIN_PERIODS (PERIODS),
        .EDGE_THRESH (THRESH),
        .SYNC_STAGES (2)
    ) u_refmon_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .ref_ok     (ref_ok),
        .sel_lock   (sel_lock),
        .win_done   (win_done),
        .last_edges (last_edges)
    );

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic exp_t model(input int n);
        exp_t e;
        e.cnt = (n > PERIODS) ? PERIODS : n;
        e.ok  = (e.cnt >= THRESH);
        return e;
    endfunction

    // Driver: called just after a close pulse; produces n rising edges well
    // inside the window, then pushes the expected result for that window.
    task automatic drive_window(input int n, input bit end_high);
        for (int k = 0; k < n; k++) begin
            ref_in = 1'b0;
            repeat (4) @(negedge clk);
            ref_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        if (!end_high && n > 0) ref_in = 1'b0;
        exp_q.push_back(model(n));
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!win_done) @(negedge clk);
    endtask

    // Monitor / scoreboard.
    int  gap = 0;
    bit  seen_first = 0;
    bit  prev_ok = 0;
    bit  prev_sat = 0;
    bit  mid_change = 0;
    bit  held_ok = 0;
    int  held_cnt = 0;

    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            gap++;
            if (!win_done) begin
                if (ref_ok !== held_ok || int'(last_edges) != held_cnt) mid_change = 1;
            end else begin
                exp_t e;
                // R2: spacing between close pulses (and from reset to the first one).
                check(seen_first ? "R2 window spacing" : "R2 first window", gap, WIN);
                gap = 0;
                seen_first = 1;
                // R8: nothing moved between closes.
                check("R8 hold between closes", int'(mid_change), 0);
                mid_change = 0;
                if (exp_q.size() == 0) begin
                    check("R2 unexpected close", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(prev_sat ? "R3 R9 edge count after saturated window"
                                   : "R3 edge count", int'(last_edges), e.cnt);
                    if (e.ok && !prev_ok)
                        check("R6 recovery to present", int'(ref_ok), 1);
                    else if (e.ok)
                        check("R5 present verdict", int'(ref_ok), 1);
                    else
                        check("R4 lost verdict", int'(ref_ok), 0);
                    check("R7 select equals verdict", int'(sel_lock), int'(e.ok));
                    prev_ok  = e.ok;
                    prev_sat = (e.cnt == PERIODS);
                end
                held_ok  = ref_ok;
                held_cnt = int'(last_edges);
            end
        end
    end

    // Main sequence.
    initial begin
        int  pat_n  [11] = '{1, 2, 3, 5, 1, 0, 2, 0, 4, 3, 1};
        bit  pat_hi [11] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held.
        check("R1 ref_ok in reset", int'(ref_ok), 0);
        check("R1 sel_lock in reset", int'(sel_lock), 0);
        check("R1 win_done in reset", int'(win_done), 0);
        check("R1 last_edges in reset", int'(last_edges), 0);
        rst_n = 1'b1;
        // First window: reference quiet.
        exp_q.push_back(model(0));
        repeat (WIN / 2) @(negedge clk);
        check("R1 lost before first close", int'(ref_ok), 0);
        wait_done();
        for (int p = 0; p < 11; p++) begin
            drive_window(pat_n[p], pat_hi[p]);
            wait_done();
        end
        // Let the last pushed window close and be scored.
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("[TB] FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule